// File: doc/BRIEF.md
# Colour Burst Gate Generator with Line-Standard Detection

This block produces the colour-burst gate for a composite video encoder. A four-phase ring counter runs at four times the subcarrier rate and yields the quadrature subcarrier phases. One phase of that counter acts as a once-per-subcarrier-cycle enable. The composite sync input is active low and asynchronous, and it is sampled only on that enable. A qualifying falling edge therefore marks the start of a line to within one subcarrier period.

A 9-bit line counter is cleared by every accepted sync edge and advances once per subcarrier cycle. When the next accepted edge arrives, the weight-256 bit of the counter shows whether the line just ended was long (PAL, about 284 cycles) or short (NTSC, about 227.5 cycles). That decision selects the burst placement for the line now beginning. Edges that arrive less than 128 counts into a line are treated as equalizing pulses and discarded.

A mode input can hand the output over to an external burst-flag input, which is synchronized first. Holding that input low in external mode removes burst altogether.

Top module: `burst_gate_gen`

## Requirements
- R1: `sc_phase` is one-hot, equals 4'b0001 after reset, and rotates one position toward the MSB on every clock; the subcarrier enable is the cycle in which `sc_phase[3]` is high.
- R2: `sync_n` is sampled only in enable cycles; an edge is accepted when its low level is seen in an enable cycle after a high level seen in the previous enable cycle.
- R3: The line counter stops at 511 and does not wrap, so a line longer than 511 subcarrier cycles is classified as PAL.
- R4: At each accepted edge after the first one following reset, `pal_detected` takes the counter's weight-256 bit (1 = PAL, 0 = NTSC). A line of 228 cycles gives 0 and a line of 284 cycles gives 1.
- R5: An edge found while the counter is below 128 is ignored. It neither restarts the line, changes `pal_detected`, nor starts a burst.
- R6: In NTSC timing, with `use_ext` low, `burst` rises 77 clocks after the clock edge that first samples low sync in an enable cycle. This is 18 subcarrier counts after the line start. It stays high for exactly 36 clocks (9 subcarrier cycles).
- R7: In PAL timing `burst` rises 101 clocks after that sampling edge (24 counts) and stays high for exactly 40 clocks (10 subcarrier cycles).
- R8: With `use_ext` high, `burst` equals `ext_flag` delayed by 3 clocks (two synchronizer stages and the output register). With `ext_flag` held low, no burst appears.
- R9: After reset `burst` and `pal_detected` are 0. No internal burst occurs until one full line has been measured, which requires two accepted edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the subcarrier frequency |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Asynchronous composite sync, active low |
| ext_flag | input | 1 | Asynchronous external burst flag, high = burst |
| use_ext | input | 1 | 1 selects the external flag, 0 the internal gate |
| sc_phase | output | 4 | One-hot quadrature subcarrier phases |
| burst | output | 1 | Registered burst gate |
| pal_detected | output | 1 | Latched standard decision, 1 = PAL |

## Verification
The assertions assume that `use_ext` is quasi-static and changes only while no internal burst window is open. They also assume that sync lows last several subcarrier cycles, so that one falling edge per pulse is seen in the enable cycles. The stimulus changes `sync_n` only on the falling clock edge inside an enable cycle, which makes every line an exact whole number of subcarrier periods. It switches the mode only after the counter has left the burst window. Line lengths are chosen on both sides of each threshold: 114 cycles for the equalizing case, 228, 284, and 600 for the saturation case.

// File: rtl/bgg_pkg.sv
package bgg_pkg;

    localparam int CNT_W = 9;
    localparam int STD_BIT = CNT_W - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] HALF_LINE = 9'd128;

    typedef enum logic {STD_NTSC = 1'b0, STD_PAL = 1'b1} line_std_e;

    typedef struct packed {
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] len;
    } burst_win_t;

    function automatic burst_win_t window_for(line_std_e s);
        burst_win_t w;
        if (s == STD_PAL) begin
            w.start = 9'd24;
            w.len   = 9'd10;
        end else begin
            w.start = 9'd18;
            w.len   = 9'd9;
        end
        return w;
    endfunction

endpackage

// File: rtl/bgg_ring.sv
module bgg_ring #(
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PHASES-1:0] phase,
    output logic              sc_en
);
    always_ff @(posedge clk) begin
        if (rst) phase <= PHASES'(1);
        else     phase <= {phase[PHASES-2:0], phase[PHASES-1]};
    end

    assign sc_en = phase[PHASES-1];
endmodule

// File: rtl/bgg_flag_sync.sv
module bgg_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bgg_sync_sampler.sv
module bgg_sync_sampler (
    input  logic clk,
    input  logic rst,
    input  logic sc_en,
    input  logic sync_n,
    output logic fall
);
    logic now_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q  <= 1'b1;
            prev_q <= 1'b1;
        end else if (sc_en) begin
            now_q  <= sync_n;
            prev_q <= now_q;
        end
    end

    assign fall = prev_q & ~now_q;
endmodule

// File: rtl/bgg_line_timer.sv
module bgg_line_timer
    import bgg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sc_en,
    input  logic             fall,
    output logic [CNT_W-1:0] cnt,
    output logic             accept,
    output logic             measured,
    output line_std_e        line_std,
    output logic             gate
);
    logic       seen;
    burst_win_t win;

    assign accept = sc_en & fall & (~seen | (cnt >= HALF_LINE));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            seen     <= 1'b0;
            measured <= 1'b0;
            line_std <= STD_NTSC;
        end else if (sc_en) begin
            if (accept) begin
                cnt  <= '0;
                seen <= 1'b1;
                if (seen) begin
                    line_std <= cnt[STD_BIT] ? STD_PAL : STD_NTSC;
                    measured <= 1'b1;
                end
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        win  = window_for(line_std);
        gate = measured && (cnt >= win.start) && (cnt < win.start + win.len);
    end
endmodule

// File: rtl/burst_gate_gen.sv
module burst_gate_gen
    import bgg_pkg::*;
#(
    parameter int PHASES      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_n,
    input  logic              ext_flag,
    input  logic              use_ext,
    output logic [PHASES-1:0] sc_phase,
    output logic              burst,
    output logic              pal_detected
);
    logic             sc_en, fall_edge, accept, measured, gate_int, ext_q;
    logic [CNT_W-1:0] cnt;
    line_std_e        line_std;

    bgg_ring #(.PHASES(PHASES)) u_ring (
        .clk(clk), .rst(rst), .phase(sc_phase), .sc_en(sc_en)
    );

    bgg_sync_sampler u_samp (
        .clk(clk), .rst(rst), .sc_en(sc_en), .sync_n(sync_n), .fall(fall_edge)
    );

    bgg_line_timer u_timer (
        .clk(clk), .rst(rst), .sc_en(sc_en), .fall(fall_edge),
        .cnt(cnt), .accept(accept), .measured(measured),
        .line_std(line_std), .gate(gate_int)
    );

    bgg_flag_sync #(.STAGES(SYNC_STAGES)) u_fsync (
        .clk(clk), .rst(rst), .d(ext_flag), .q(ext_q)
    );

    always_ff @(posedge clk) begin
        if (rst) burst <= 1'b0;
        else     burst <= use_ext ? ext_q : gate_int;
    end

    assign pal_detected = (line_std == STD_PAL);
endmodule

// File: rtl/burst_gate_gen_chk.sv
module burst_gate_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] sc_phase,
    input logic       sc_en,
    input logic       fall_edge,
    input logic       accept,
    input logic       measured,
    input logic [8:0] cnt,
    input logic       use_ext,
    input logic       ext_q,
    input logic       burst,
    input logic       pal_detected
);
    p_ring_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(sc_phase) == 1);

    p_ring_rotate_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> sc_phase == {$past(sc_phase[2:0]), $past(sc_phase[3])});

    p_accept_on_en_r2: assert property (@(posedge clk) disable iff (rst)
        accept |-> sc_en && fall_edge);

    p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == 9'd511 && !accept) |=> cnt == 9'd511);

    p_std_on_accept_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(pal_detected) && !$past(rst) |-> $past(accept));

    p_reject_short_r5: assert property (@(posedge clk) disable iff (rst)
        (sc_en && measured && cnt < 9'd128) |=> cnt == 9'($past(cnt) + 9'd1));

    p_ext_follow_r8: assert property (@(posedge clk) disable iff (rst)
        (use_ext && !$past(rst)) |=> burst == $past(ext_q));

    p_quiet_unmeasured_r9: assert property (@(posedge clk) disable iff (rst)
        (!use_ext && !measured) |=> !burst);
endmodule

bind burst_gate_gen burst_gate_gen_chk u_chk (
    .clk(clk), .rst(rst), .sc_phase(sc_phase), .sc_en(sc_en),
    .fall_edge(fall_edge), .accept(accept), .measured(measured), .cnt(cnt),
    .use_ext(use_ext), .ext_q(ext_q), .burst(burst), .pal_detected(pal_detected)
);

// File: tb/burst_gate_gen_tb.sv
module burst_gate_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_n = 1'b1;
    logic       ext_flag = 1'b0;
    logic       use_ext = 1'b0;
    logic [3:0] sc_phase;
    logic       burst, pal_detected;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    typedef struct {
        int    rise;
        int    len;
        string req;
    } exp_t;
    exp_t exp_q[$];

    // bench model of the line decision, derived from R2..R5, R9
    bit m_seen = 0, m_meas = 0, m_pal = 0, m_ext = 0;
    int m_last = 0;

    burst_gate_gen u_dut (
        .clk(clk), .rst(rst), .sync_n(sync_n), .ext_flag(ext_flag),
        .use_ext(use_ext), .sc_phase(sc_phase), .burst(burst),
        .pal_detected(pal_detected)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // monitor: measures each burst pulse and compares against the queue
    bit prev_b = 0;
    int rise_at = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (burst && !prev_b) rise_at = cyc;
            if (!burst && prev_b) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5/R9 unexpected burst", rise_at, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rise_at == e.rise, {e.req, " rise"}, rise_at, e.rise);
                    check(cyc - rise_at == e.len, {e.req, " length"}, cyc - rise_at, e.len);
                end
            end
            prev_b = burst;
        end
    end

    // one line: sync falls now (negedge inside enable cycle), n subcarrier cycles long
    task automatic line(int n);
        int p, c;
        exp_t e;
        sync_n = 1'b0;
        p = cyc + 1;
        c = (p - m_last) / 4 - 1;
        if (c > 511) c = 511;
        if (!m_seen || c >= 128) begin
            if (m_seen) begin
                m_pal  = (c >= 256);
                m_meas = 1;
            end
            m_seen = 1;
            m_last = p;
            if (m_meas && !m_ext) begin
                e.rise = p + 5 + 4 * (m_pal ? 24 : 18);
                e.len  = 4 * (m_pal ? 10 : 9);
                e.req  = m_pal ? "R7 PAL burst" : "R6 NTSC burst";
                exp_q.push_back(e);
            end
        end
        repeat (32) @(negedge clk);
        sync_n = 1'b1;
        repeat (4 * n - 32) @(negedge clk);
        check(pal_detected == m_pal, "R4/R5 pal_detected", pal_detected, m_pal);
    endtask

    task automatic ext_pulse(int len);
        exp_t e;
        ext_flag = 1'b1;
        e.rise = cyc + 3;
        e.len  = len;
        e.req  = "R8 external flag";
        exp_q.push_back(e);
        repeat (len) @(negedge clk);
        ext_flag = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic align();
        @(negedge clk);
        while (sc_phase != 4'b1000) @(negedge clk);
    endtask

    initial begin
        bit timeout;
        timeout = 0;
        fork
            begin
                repeat (5) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                check(burst == 1'b0, "R9 reset burst", burst, 0);
                check(pal_detected == 1'b0, "R9 reset pal", pal_detected, 0);
                check(sc_phase == 4'b0001, "R1 reset phase", sc_phase, 1);
                @(negedge clk);
                check(sc_phase == 4'b0010, "R1 rotate", sc_phase, 2);
                align();
                // R9: first edge gives no burst; R6 steady NTSC lines
                repeat (4) line(228);
                // R5: equalizing half-line edges are ignored
                line(114);
                line(114);
                line(114);
                line(114);
                // R7 / R4: PAL lines
                repeat (3) line(284);
                repeat (2) line(228);
                // R3: overlong line saturates and reads as PAL
                line(600);
                line(228);
                line(228);
                // R8: external mode, flag low suppresses burst
                use_ext = 1'b1;
                m_ext = 1;
                line(228);
                line(228);
                ext_pulse(20);
                ext_pulse(7);
                repeat (400) @(negedge clk);
                check(burst == 1'b0, "R8 flag low", burst, 0);
                use_ext = 1'b0;
                m_ext = 0;
                align();
                line(228);
                line(228);
                line(284);
                repeat (200) @(negedge clk);
                check(exp_q.size() == 0, "R6/R7 missing bursts", exp_q.size(), 0);
            end
            begin
                repeat (150000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule